// File: doc/BRIEF.md
# Multiplexed-Bus Line Reader with Refill Queue

This block fetches cache-miss data over a shared 32-bit address/data bus. A request carries an address, a flag selecting a one-word or a four-word (line) read, and a flag selecting how a line read is paced. The block drives the address onto the bus for one cycle with an address-latch strobe, which lets external latches hold the address. It then releases the bus for one turnaround cycle and raises a read strobe while memory returns data.

One-word reads always wait for an acknowledge. Line reads take either one word per acknowledge or, in burst mode, one acknowledge for the first word followed by one word on each of the next clocks. Returned words collect in a four-entry queue. Once the read is finished, the queue is emptied into the cache one word per clock, and a one-cycle completion pulse follows.

Top module: `rdq_bus_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `ale`, `ad_oe`, `rd_strobe`, `fill_valid` and `done` are all 0.
- R2: In the cycle after a request is accepted, `ale` and `ad_oe` are both 1 for exactly one cycle. During that cycle `ad_out` carries the request address, with bits 3:0 cleared for a line read or bits 1:0 cleared for a one-word read.
- R3: The cycle after the address cycle is a turnaround in which `ale`, `ad_oe` and `rd_strobe` are all 0. `rd_strobe` goes to 1 in the following cycle and stays at 1 while words are still owed.
- R4: A one-word read captures `ad_in` in the first data cycle in which `ack` is 1. The burst flag has no effect on a one-word read.
- R5: A handshake-paced line read captures exactly one word for each data cycle in which `ack` is 1. Cycles with `ack` at 0 capture nothing and leave the read strobe high.
- R6: A burst line read captures its first word on `ack`. It then captures `ad_in` on each of the next three clocks, whatever the value of `ack`.
- R7: `rd_strobe` is 0 from the cycle after the final word (first for one-word, fourth for line) is captured.
- R8: After the final capture, the queued words appear on `fill_data` with `fill_valid` at 1, one per clock, in capture order. `fill_idx` counts up from 0 and `fill_addr` equals the aligned address plus 4 times `fill_idx`. `fill_valid` is never 1 while `rd_strobe` or `ad_oe` is 1.
- R9: `done` is 1 for one cycle, in the cycle right after the last queued word is delivered. The block is idle (`req_ready` at 1) in the cycle after that.
- R10: `req_valid` has no effect while `req_ready` is 0, so no second address cycle follows a request made during a busy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request, taken when `req_ready` is 1 |
| req_addr | input | 32 | Byte address of the miss |
| req_quad | input | 1 | 1 for a four-word line read, 0 for a one-word read |
| req_burst | input | 1 | 1 selects clock-rate burst pacing for line reads |
| req_ready | output | 1 | Block is idle and accepts a request |
| ad_out | output | 32 | Value driven onto the shared bus |
| ad_oe | output | 1 | Bus output enable (address cycle) |
| ad_in | input | 32 | Value sampled from the shared bus |
| ale | output | 1 | Address-latch strobe |
| rd_strobe | output | 1 | Read strobe, high while data is owed |
| ack | input | 1 | Memory acknowledge |
| fill_valid | output | 1 | Refill word valid toward the cache |
| fill_data | output | 32 | Refill word |
| fill_idx | output | 2 | Word index within the refill |
| fill_addr | output | 32 | Byte address of the refill word |
| done | output | 1 | One-cycle completion pulse |

## Verification
One-word reads are run with the burst flag at 0 and at 1, with and without wait cycles, to show that pacing only affects line reads. Line reads are run in handshake mode with no gaps and with two-cycle gaps, which separates per-acknowledge capture from capture on every clock. They are also run in burst mode with an acknowledge pattern that toggles after the first word, which shows that later words do not wait on `ack`. A line address near the top of the address space and unaligned request addresses exercise the alignment and refill address arithmetic. Requests raised during a busy read check that they are dropped.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_TURN  = 3'd2,
        PH_DATA  = 3'd3,
        PH_DRAIN = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/rdq_fifo.sv
module rdq_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + PTR_W'(1);
        end
        if (do_pop) begin
            d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CNT_W'(1);
            2'b01:   d.cnt = q.cnt - CNT_W'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;

endmodule

// File: rtl/rdq_seq.sv
module rdq_seq
    import rdq_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned LINE_WORDS = 4,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned CNT_W     = $clog2(LINE_WORDS + 1),
    localparam int unsigned LINE_B    = LINE_WORDS * WORD_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_quad,
    input  logic             req_burst,
    input  logic             ack,
    input  logic [CNT_W-1:0] fifo_cnt,
    output logic             req_ready,
    output logic             ale,
    output logic             ad_oe,
    output logic [AW-1:0]    ad_out,
    output logic             rd_strobe,
    output logic             capture,
    output logic             pop,
    output logic             done,
    output logic [IDX_W-1:0] fill_idx,
    output logic [AW-1:0]    fill_addr
);

    localparam logic [AW-1:0] LINE_MASK = AW'(LINE_B - 1);
    localparam logic [AW-1:0] WORD_MASK = AW'(WORD_BYTES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [AW-1:0]    base;
        logic             quad;
        logic             burst;
        logic [CNT_W-1:0] got;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] total;
    logic             need_ack;

    always_comb begin
        d         = q;
        req_ready = 1'b0;
        ale       = 1'b0;
        ad_oe     = 1'b0;
        rd_strobe = 1'b0;
        capture   = 1'b0;
        pop       = 1'b0;
        done      = 1'b0;
        total     = q.quad ? CNT_W'(LINE_WORDS) : CNT_W'(1);
        need_ack  = (q.got == '0) || !q.burst || !q.quad;
        case (q.ph)
            PH_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.ph    = PH_ADDR;
                    d.quad  = req_quad;
                    d.burst = req_burst;
                    d.base  = req_addr & ~(req_quad ? LINE_MASK : WORD_MASK);
                    d.got   = '0;
                    d.idx   = '0;
                end
            end
            PH_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
                d.ph  = PH_TURN;
            end
            PH_TURN: begin
                d.ph = PH_DATA;
            end
            PH_DATA: begin
                rd_strobe = 1'b1;
                capture   = need_ack ? ack : 1'b1;
                if (capture) begin
                    d.got = q.got + CNT_W'(1);
                    if (q.got == total - CNT_W'(1)) d.ph = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                pop = (fifo_cnt != '0);
                if (pop) begin
                    d.idx = q.idx + IDX_W'(1);
                    if (fifo_cnt == CNT_W'(1)) d.ph = PH_DONE;
                end
            end
            PH_DONE: begin
                done = 1'b1;
                d.ph = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ad_out    = ad_oe ? q.base : '0;
    assign fill_idx  = q.idx;
    assign fill_addr = q.base + (AW'(q.idx) << 2);

endmodule

// File: rtl/rdq_bus_unit.sv
module rdq_bus_unit #(
    parameter int unsigned AW         = 32,
    parameter int unsigned LINE_WORDS = 4,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned CNT_W     = $clog2(LINE_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_quad,
    input  logic             req_burst,
    output logic             req_ready,
    output logic [AW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [AW-1:0]    ad_in,
    output logic             ale,
    output logic             rd_strobe,
    input  logic             ack,
    output logic             fill_valid,
    output logic [AW-1:0]    fill_data,
    output logic [IDX_W-1:0] fill_idx,
    output logic [AW-1:0]    fill_addr,
    output logic             done
);

    logic             capture;
    logic             pop;
    logic [CNT_W-1:0] fifo_cnt;

    rdq_seq #(
        .AW         (AW),
        .LINE_WORDS (LINE_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_quad  (req_quad),
        .req_burst (req_burst),
        .ack       (ack),
        .fifo_cnt  (fifo_cnt),
        .req_ready (req_ready),
        .ale       (ale),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out),
        .rd_strobe (rd_strobe),
        .capture   (capture),
        .pop       (pop),
        .done      (done),
        .fill_idx  (fill_idx),
        .fill_addr (fill_addr)
    );

    rdq_fifo #(
        .W     (AW),
        .DEPTH (LINE_WORDS)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (capture),
        .wdata (ad_in),
        .pop   (pop),
        .rdata (fill_data),
        .count (fifo_cnt)
    );

    assign fill_valid = pop;

endmodule

// File: rtl/rdq_bus_unit_chk.sv
module rdq_bus_unit_chk #(
    parameter int unsigned LINE_WORDS = 4,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ad_oe,
    input logic             ale,
    input logic             rd_strobe,
    input logic             fill_valid,
    input logic [IDX_W-1:0] fill_idx,
    input logic             done
);

    a_r2_ale_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r2_ale_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && !rd_strobe));

    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ad_oe && !rd_strobe));

    a_r3_strobe_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> !ad_oe);

    a_r8_fill_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (!rd_strobe && !ad_oe && !req_ready));

    a_r8_idx_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && $past(fill_valid)) |-> (fill_idx == $past(fill_idx) + IDX_W'(1)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r9_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fill_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && !rd_strobe && !fill_valid && !done));

endmodule

bind rdq_bus_unit rdq_bus_unit_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .rd_strobe  (rd_strobe),
    .fill_valid (fill_valid),
    .fill_idx   (fill_idx),
    .done       (done)
);

// File: tb/rdq_bus_unit_test.sv
module rdq_bus_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_quad;
    logic        req_burst;
    logic        req_ready;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [31:0] ad_in;
    logic        ale;
    logic        rd_strobe;
    logic        ack;
    logic        fill_valid;
    logic [31:0] fill_data;
    logic [1:0]  fill_idx;
    logic [31:0] fill_addr;
    logic        done;

    int tests = 0;
    int fails = 0;

    rdq_bus_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_quad   (req_quad),
        .req_burst  (req_burst),
        .req_ready  (req_ready),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ad_in      (ad_in),
        .ale        (ale),
        .rd_strobe  (rd_strobe),
        .ack        (ack),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .fill_idx   (fill_idx),
        .fill_addr  (fill_addr),
        .done       (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F11;
    endfunction

    task automatic idle_chk(input string tag);
        chk({tag, " ready"}, 32'(req_ready), 32'd1);
        chk({tag, " ale"}, 32'(ale), 32'd0);
        chk({tag, " oe"}, 32'(ad_oe), 32'd0);
        chk({tag, " rd"}, 32'(rd_strobe), 32'd0);
        chk({tag, " fill"}, 32'(fill_valid), 32'd0);
        chk({tag, " done"}, 32'(done), 32'd0);
    endtask

    // One read, checked on every clock against the expected timeline.
    task automatic run_read(input logic [31:0] a, input bit quad, input bit burst, input int gap);
        logic [31:0] base;
        logic [31:0] w [4];
        int n;
        n    = quad ? 4 : 1;
        base = quad ? (a & ~32'hF) : (a & ~32'h3);
        for (int i = 0; i < 4; i++) w[i] = mem_word(base + 32'(4 * i));

        req_valid = 1'b1; req_addr = a; req_quad = quad; req_burst = burst;
        @(negedge clk);
        // R2: address cycle
        chk("R2 ale", 32'(ale), 32'd1);
        chk("R2 oe", 32'(ad_oe), 32'd1);
        chk("R2 addr", ad_out, base);
        chk("R2 rd", 32'(rd_strobe), 32'd0);
        chk("R10 ready busy", 32'(req_ready), 32'd0);
        // R10: keep asking while busy, with a different address
        req_addr = a ^ 32'h0F00_0000;
        @(negedge clk);
        // R3: turnaround
        chk("R3 ale", 32'(ale), 32'd0);
        chk("R3 oe", 32'(ad_oe), 32'd0);
        chk("R3 rd", 32'(rd_strobe), 32'd0);
        @(negedge clk);
        chk("R3 rd up", 32'(rd_strobe), 32'd1);
        chk("R8 no fill in read", 32'(fill_valid), 32'd0);

        for (int i = 0; i < n; i++) begin
            if (i == 0 || !burst || !quad) begin
                for (int g = 0; g < gap; g++) begin
                    ack = 1'b0; ad_in = 32'hDEAD_0000 | 32'(g);
                    @(negedge clk);
                    chk("R5 wait keeps rd", 32'(rd_strobe), 32'd1);
                    chk("R5 wait no fill", 32'(fill_valid), 32'd0);
                end
                ack = 1'b1; ad_in = w[i];
            end else begin
                // R6: ack toggles freely, words still taken every clock
                ack = i[0] ? 1'b0 : 1'b1; ad_in = w[i];
            end
            @(negedge clk);
            if (i < n - 1) chk("R5/R6 rd held", 32'(rd_strobe), 32'd1);
            else           chk("R7 rd drops", 32'(rd_strobe), 32'd0);
        end
        ack = 1'b0; ad_in = 32'h0; req_valid = 1'b0;

        for (int j = 0; j < n; j++) begin
            chk("R8 fill valid", 32'(fill_valid), 32'd1);
            chk("R8 fill idx", 32'(fill_idx), 32'(j));
            chk(quad ? "R8 fill data" : "R4 single data", fill_data, w[j]);
            chk("R8 fill addr", fill_addr, base + 32'(4 * j));
            chk("R9 no early done", 32'(done), 32'd0);
            @(negedge clk);
        end
        chk("R9 done", 32'(done), 32'd1);
        chk("R9 fill off", 32'(fill_valid), 32'd0);
        @(negedge clk);
        idle_chk("R9/R10 idle after");
        @(negedge clk);
        chk("R10 no extra addr", 32'(ale), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_quad = 1'b0;
        req_burst = 1'b0; ad_in = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        idle_chk("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 after reset");

        run_read(32'h1000_0007, 1'b0, 1'b0, 0);  // R4 single, no wait
        run_read(32'h1234_5672, 1'b0, 1'b1, 2);  // R4 burst flag ignored
        run_read(32'h2000_003C, 1'b1, 1'b0, 0);  // R5 handshake, back to back
        run_read(32'h3000_0104, 1'b1, 1'b0, 2);  // R5 handshake with waits
        run_read(32'h4000_0020, 1'b1, 1'b1, 0);  // R6 burst
        run_read(32'hFFFF_FFF8, 1'b1, 1'b1, 3);  // R6 burst, top of space
        run_read(32'h0000_0009, 1'b1, 1'b0, 1);  // R8 low line

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule